// File: doc/BRIEF.md
# Eight-Point Fast Forward Cosine Transform Pipeline

This block takes a row of eight signed fixed-point samples and returns the eight coefficients of its one-dimensional forward discrete cosine transform. All eight samples enter in one clock with a valid strobe. The eight coefficients leave together, with their own valid strobe, a fixed number of cycles later. The pipeline takes a new row on every clock, so a 2-D transform unit can stream rows or columns through it without stalls.

The arithmetic follows a fast factorisation with four dependent stages and one register bank after each stage. Stage one pairs mirrored samples in butterflies. From stage two the flow splits into an even half and an odd half. The even half is a four-point transform, which splits again at stage three. Two odd rotations by 3π/16 and π/16 happen at stage two. A scaled even rotation by 6π/16 happens at stage three. The last stage does a butterfly on the outer odd terms and scales the two middle odd terms by √2. Each rotation uses three constant multipliers, which gives eleven multipliers and twenty-nine adders in all. All constants are signed fixed-point values with 14 fraction bits. Each rotator and scaler output is rounded half-up before the next register. The outputs are the orthonormal transform scaled by √8, so coefficient 0 is the plain sum of the samples.

Top module: `dct8_loeffler`

## Requirements
- R1: Coefficient 0 equals the exact sum of the eight input samples.
- R2: Coefficient 4 equals exactly (x0+x3+x4+x7) − (x1+x2+x5+x6).
- R3: For k in {1,2,3,5,6,7}, coefficient k is within ±4 LSB of √2·Σn xn·cos((2n+1)kπ/16), for every input in the full signed range.
- R4: Sample n is read two's complement from in_smp[n*DW +: DW]. Coefficient k is driven two's complement on out_coef[k*OW +: OW], with OW = DW+4, in natural order 0 to 7.
- R5: Consider a vector sampled with in_valid high at clock edge n. Its coefficients appear with out_valid high right after edge n+3. Vectors sampled on consecutive edges come out on consecutive cycles.
- R6: out_valid is high only in the cycles named by R5. Data presented with in_valid low never produces an output.
- R7: A synchronous active-high reset clears every in-flight valid bit. After a clock edge that samples rst high, out_valid is low, and vectors in flight at that edge never come out.
- R8: When all eight samples are equal, including both full-scale extremes, every coefficient other than 0 is exactly zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Input vector strobe |
| in_smp | input | 8*DW | Eight packed signed samples, sample n at bits n*DW |
| out_valid | output | 1 | Output vector strobe |
| out_coef | output | 8*OW | Eight packed signed coefficients, coefficient k at bits k*OW |

## Verification
The bench builds the block with its default sample width of 12 bits, so the outputs are 16 bits wide. At that width, rows filled with −2048 or +2047, alternating full-scale rows and single full-scale impulses at each position can all be driven. These reach the largest coefficient magnitudes and the worst rounding build-up on the odd path. The bench mixes back-to-back streams with gaps that carry junk data, and it resets in mid-stream. This exercises both the fixed latency and the flush of vectors already in flight.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
    // Fixed-point format of every multiplier constant: signed, 14 fraction bits.
    localparam int CFRAC = 14;
    localparam int CW    = 16;
    localparam int NPT   = 8;
    localparam int HALF_NPT = NPT / 2;
    localparam int LAT   = 4;

    typedef logic signed [CW-1:0] coef_t;

    // Odd-half rotation constants (angles 3pi/16 and pi/16).
    localparam coef_t K_COS3 = 16'sd13623;
    localparam coef_t K_SIN3 = 16'sd9102;
    localparam coef_t K_COS1 = 16'sd16069;
    localparam coef_t K_SIN1 = 16'sd3196;
    // Even-half rotation, scaled by sqrt(2): sqrt2*cos(6pi/16), sqrt2*cos(2pi/16).
    localparam coef_t K_E6   = 16'sd8867;
    localparam coef_t K_E2   = 16'sd21407;
    // Square root of two.
    localparam coef_t K_RT2  = 16'sd23170;
endpackage

// File: rtl/dct8_rot3m.sv
module dct8_rot3m
    import dct8_pkg::*;
#(
    parameter int    IW = 16,
    parameter coef_t KP = K_COS3,
    parameter coef_t KQ = K_SIN3
) (
    input  logic signed [IW-1:0] in0,
    input  logic signed [IW-1:0] in1,
    output logic signed [IW-1:0] out0,
    output logic signed [IW-1:0] out1
);
    // out0 = KP*in0 + KQ*in1 ; out1 = KP*in1 - KQ*in0, using three products.
    localparam int PW = IW + CW + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CFRAC - 1);
    localparam logic signed [CW:0] KSUM = (CW+1)'(KP) + (CW+1)'(KQ);
    localparam logic signed [CW:0] KDIF = (CW+1)'(KQ) - (CW+1)'(KP);

    logic signed [IW:0]   pre;
    logic signed [PW-1:0] shared, acc0, acc1;

    always_comb begin
        pre    = (IW+1)'(in0) + (IW+1)'(in1);
        shared = PW'(pre) * PW'(KP);
        acc0   = shared + PW'(in1) * PW'(KDIF) + HALF;
        acc1   = shared - PW'(in0) * PW'(KSUM) + HALF;
        out0   = IW'(acc0 >>> CFRAC);
        out1   = IW'(acc1 >>> CFRAC);
    end
endmodule

// File: rtl/dct8_cmul.sv
module dct8_cmul
    import dct8_pkg::*;
#(
    parameter int    IW = 16,
    parameter coef_t K  = K_RT2
) (
    input  logic signed [IW-1:0] din,
    output logic signed [IW-1:0] dout
);
    localparam int PW = IW + CW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CFRAC - 1);

    logic signed [PW-1:0] prod;

    always_comb begin
        prod = PW'(din) * PW'(K) + HALF;
        dout = IW'(prod >>> CFRAC);
    end
endmodule

// File: rtl/dct8_loeffler.sv
module dct8_loeffler
    import dct8_pkg::*;
#(
    parameter  int DW = 12,
    localparam int OW = DW + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [8*DW-1:0]   in_smp,
    output logic              out_valid,
    output logic [8*OW-1:0]   out_coef
);
    localparam int IW = OW;

    // ---------------- input unpacking ----------------
    logic signed [IW-1:0] x [NPT];
    for (genvar n = 0; n < NPT; n++) begin : g_unpack
        assign x[n] = IW'(signed'(in_smp[n*DW +: DW]));
    end

    // ---------------- stage 1: mirrored butterflies ----------------
    logic signed [IW-1:0] st1_sum [HALF_NPT];
    logic signed [IW-1:0] st1_dif [HALF_NPT];
    logic signed [IW-1:0] s1_sum  [HALF_NPT];
    logic signed [IW-1:0] s1_dif  [HALF_NPT];
    for (genvar i = 0; i < HALF_NPT; i++) begin : g_bfly1
        assign st1_sum[i] = x[i] + x[NPT-1-i];
        assign st1_dif[i] = x[i] - x[NPT-1-i];
    end

    always_ff @(posedge clk) begin
        s1_sum <= st1_sum;
        s1_dif <= st1_dif;
    end

    // ---------------- stage 2: even butterflies, odd rotations ----------------
    // Odd terms: dif[3]=x3-x4, dif[2]=x2-x5, dif[1]=x1-x6, dif[0]=x0-x7.
    logic signed [IW-1:0] ev_b0, ev_b1, ev_b2, ev_b3;
    logic signed [IW-1:0] od_r4, od_r7, od_r5, od_r6;
    logic signed [IW-1:0] s2_b0, s2_b1, s2_b2, s2_b3;
    logic signed [IW-1:0] s2_o4, s2_o5, s2_o6, s2_o7;

    assign ev_b0 = s1_sum[0] + s1_sum[3];
    assign ev_b1 = s1_sum[1] + s1_sum[2];
    assign ev_b2 = s1_sum[1] - s1_sum[2];
    assign ev_b3 = s1_sum[0] - s1_sum[3];

    dct8_rot3m #(.IW(IW), .KP(K_COS3), .KQ(K_SIN3)) u_rot_c3 (
        .in0(s1_dif[3]), .in1(s1_dif[0]), .out0(od_r4), .out1(od_r7));
    dct8_rot3m #(.IW(IW), .KP(K_COS1), .KQ(K_SIN1)) u_rot_c1 (
        .in0(s1_dif[2]), .in1(s1_dif[1]), .out0(od_r5), .out1(od_r6));

    always_ff @(posedge clk) begin
        s2_b0 <= ev_b0; s2_b1 <= ev_b1; s2_b2 <= ev_b2; s2_b3 <= ev_b3;
        s2_o4 <= od_r4; s2_o5 <= od_r5; s2_o6 <= od_r6; s2_o7 <= od_r7;
    end

    // ---------------- stage 3: even split, odd butterflies ----------------
    logic signed [IW-1:0] c_y2, c_y6;
    logic signed [IW-1:0] s3_y0, s3_y2, s3_y4, s3_y6;
    logic signed [IW-1:0] s3_p4, s3_p5, s3_p6, s3_p7;

    dct8_rot3m #(.IW(IW), .KP(K_E6), .KQ(K_E2)) u_rot_c6 (
        .in0(s2_b2), .in1(s2_b3), .out0(c_y2), .out1(c_y6));

    always_ff @(posedge clk) begin
        s3_y0 <= s2_b0 + s2_b1;
        s3_y4 <= s2_b0 - s2_b1;
        s3_y2 <= c_y2;
        s3_y6 <= c_y6;
        s3_p4 <= s2_o4 + s2_o6;
        s3_p6 <= s2_o4 - s2_o6;
        s3_p7 <= s2_o7 + s2_o5;
        s3_p5 <= s2_o7 - s2_o5;
    end

    // ---------------- stage 4: outer odd butterfly, sqrt2 scaling ----------------
    logic signed [IW-1:0] c_y3, c_y5;
    logic signed [IW-1:0] y [NPT];

    dct8_cmul #(.IW(IW), .K(K_RT2)) u_rt2_a (.din(s3_p5), .dout(c_y3));
    dct8_cmul #(.IW(IW), .K(K_RT2)) u_rt2_b (.din(s3_p6), .dout(c_y5));

    always_ff @(posedge clk) begin
        y[0] <= s3_y0;
        y[1] <= s3_p7 + s3_p4;
        y[2] <= s3_y2;
        y[3] <= c_y3;
        y[4] <= s3_y4;
        y[5] <= c_y5;
        y[6] <= s3_y6;
        y[7] <= s3_p7 - s3_p4;
    end

    for (genvar k = 0; k < NPT; k++) begin : g_pack
        assign out_coef[k*OW +: OW] = y[k];
    end

    // ---------------- valid pipeline ----------------
    logic [LAT-1:0] vld;
    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= {vld[LAT-2:0], in_valid};
    end
    assign out_valid = vld[LAT-1];

    // ---------------- assertions ----------------
    logic [2:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 3'd4) age <= age + 3'd1;
    end

    logic signed [OW-1:0] in_tot, in_alt;
    always_comb begin
        in_tot = x[0] + x[1] + x[2] + x[3] + x[4] + x[5] + x[6] + x[7];
        in_alt = x[0] - x[1] - x[2] + x[3] + x[4] - x[5] - x[6] + x[7];
    end

    // R5: strobe emerges exactly four sampled edges after it entered.
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R1: coefficient 0 is the exact sample sum of the matching input.
    a_r1_dc_exact: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4 && out_valid) |-> ($signed(out_coef[0 +: OW]) == $past(in_tot, 4)));

    // R2: coefficient 4 is the exact alternating-pair sum of the matching input.
    a_r2_mid_exact: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4 && out_valid) |-> ($signed(out_coef[4*OW +: OW]) == $past(in_alt, 4)));

    // R7: after an edge that sampled reset, nothing is valid.
    a_r7_reset_flush: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/dct8_loeffler_tb_top.sv
module dct8_loeffler_tb_top;
    localparam int  DW  = 12;
    localparam int  OW  = DW + 4;
    localparam real TOL = 4.0;
    localparam real PI  = 3.14159265358979323846;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [8*DW-1:0] in_smp = '0;
    logic            out_valid;
    logic [8*OW-1:0] out_coef;

    always #10 clk = ~clk;  // 50 MHz

    dct8_loeffler #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_smp(in_smp),
        .out_valid(out_valid), .out_coef(out_coef));

    typedef struct {
        int    due;
        int    smp[8];
        string tag;
    } exp_t;

    exp_t q[$];
    int   ec = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic compare(input exp_t e);
        bit all_eq;
        all_eq = 1'b1;
        for (int n = 1; n < 8; n++) if (e.smp[n] != e.smp[0]) all_eq = 1'b0;
        for (int k = 0; k < 8; k++) begin
            longint got;
            got = longint'($signed(out_coef[k*OW +: OW]));
            if (k == 0) begin
                longint s;
                s = 0;
                for (int n = 0; n < 8; n++) s += e.smp[n];
                check(got == s, "R1", "coef0 sum", got, s);
            end else if (k == 4) begin
                longint s;
                s = e.smp[0] - e.smp[1] - e.smp[2] + e.smp[3]
                  + e.smp[4] - e.smp[5] - e.smp[6] + e.smp[7];
                check(got == s, "R2", "coef4 alternating sum", got, s);
            end else if (all_eq) begin
                check(got == 0, "R8", $sformatf("coef%0d of flat row", k), got, 0);
            end else begin
                real r, d;
                r = 0.0;
                for (int n = 0; n < 8; n++)
                    r += real'(e.smp[n]) * $cos(real'((2*n+1)*k) * PI / 16.0);
                r = r * $sqrt(2.0);
                d = r - real'(got);
                if (d < 0.0) d = -d;
                check(d <= TOL, e.tag, $sformatf("coef%0d", k), got,
                      longint'($rtoi(r + ((r >= 0.0) ? 0.5 : -0.5))));
            end
        end
    endtask

    // Monitor: samples 5 ns after each rising edge.
    always @(posedge clk) begin
        logic rs;
        rs = rst;
        ec++;
        #5;
        if (!done) begin
            if (rs) begin
                check(out_valid == 1'b0, "R7", "out_valid after reset edge", out_valid, 0);
            end else if (q.size() > 0 && q[0].due == ec) begin
                check(out_valid == 1'b1, "R5", "out_valid at due cycle", out_valid, 1);
                compare(q[0]);
                void'(q.pop_front());
            end else begin
                check(out_valid == 1'b0, "R6", "out_valid with nothing due", out_valid, 0);
            end
        end
    end

    task automatic drive(input int s[8], input bit v, input string tag);
        exp_t e;
        @(negedge clk);
        for (int n = 0; n < 8; n++) in_smp[n*DW +: DW] = DW'(s[n]);
        in_valid = v;
        if (v) begin
            e.due = ec + 4;
            e.smp = s;
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        int s[8];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // Flat rows, including full-scale extremes (R8).
        for (int n = 0; n < 8; n++) s[n] = 0;
        drive(s, 1'b1, "R8");
        for (int n = 0; n < 8; n++) s[n] = 5;
        drive(s, 1'b1, "R8");
        for (int n = 0; n < 8; n++) s[n] = 2047;
        drive(s, 1'b1, "R8");
        for (int n = 0; n < 8; n++) s[n] = -2048;
        drive(s, 1'b1, "R8");

        // Impulses at every position check the packing order (R4).
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) s[n] = (n == p) ? 2047 : 0;
            drive(s, 1'b1, "R4");
        end
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) s[n] = (n == p) ? -2048 : 0;
            drive(s, 1'b1, "R4");
        end

        // Alternating full scale and ramps (R3).
        for (int n = 0; n < 8; n++) s[n] = (n % 2 == 0) ? 2047 : -2048;
        drive(s, 1'b1, "R3");
        for (int n = 0; n < 8; n++) s[n] = (n < 4) ? -2048 : 2047;
        drive(s, 1'b1, "R3");
        for (int n = 0; n < 8; n++) s[n] = n * 500 - 1750;
        drive(s, 1'b1, "R3");
        idle(6);

        // Gaps with junk data on the bus (R6).
        for (int i = 0; i < 40; i++) begin
            for (int n = 0; n < 8; n++) s[n] = int'($urandom_range(4095)) - 2048;
            drive(s, (i % 3) != 1, "R3");
        end
        idle(3);

        // Reset in mid-stream flushes in-flight vectors (R7).
        for (int i = 0; i < 3; i++) begin
            for (int n = 0; n < 8; n++) s[n] = int'($urandom_range(4095)) - 2048;
            drive(s, 1'b1, "R3");
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idle(6);

        // Long back-to-back random stream (R3, R5).
        for (int i = 0; i < 400; i++) begin
            for (int n = 0; n < 8; n++) s[n] = int'($urandom_range(4095)) - 2048;
            drive(s, 1'b1, "R3");
        end
        idle(8);
        check(q.size() == 0, "R5", "vectors never delivered", q.size(), 0);

        summary();
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule